// File: doc/BRIEF.md
# Rotator Relay and Brake Sequencer

This block drives the relay bank of an antenna rotator. It has an 8-bit relay data group and two azimuth direction lines. A requester asks for a motion as a 4-bit direction word (left, right, up, down, or none of them). The sequencer then moves the relays through a safe order. On a reversal it first de-energises the affected relays and pauses to let the mechanics settle. Before azimuth motion it releases the brake and pauses. Only then does it apply the new drive pattern. When the final relay state is on the pins, it pulses an acknowledge.

The relay data group is read-modify-write. Each step sets some bits and clears others, and leaves every other bit as it was. A parameter picks one of two wiring variants: a rotator with azimuth only, or one with azimuth and elevation. The two variants use different bit patterns. A stop input overrides everything within one clock. The pause lengths are given in milliseconds and converted to clock cycles from a clock-rate parameter given in kHz.

Top module: `rotor_relay_seq`

## Requirements
- R1: An azimuth reversal is a request with the right bit (`req_dir[1]`) while the remembered move has left (bit 0), or the other way round. On a reversal the block first clears data bits 0, 2 and 6, drops both direction lines and marks the brake engaged. It then waits `SETTLE_MS` before going on.
- R2: This applies to the elevation variant only. An up (bit 2) to down (bit 3) reversal, or the reverse, first clears data bits 1 and 5 and then waits the same settle time. The azimuth-only variant ignores elevation reversals.
- R3: When the brake is engaged and the request has left or right, the block drops both lines and applies the release pattern. It then marks the brake released and waits `BRAKE_MS`. The release pattern is: elevation variant, set bits 0, 2, 4 and 6 and clear bit 7; azimuth-only variant, set bits 0, 2, 4, 5, 6 and 7 and clear bits 1 and 3. Requests with no azimuth component never wait for the brake. Only a reversal or a stop re-engages the brake.
- R4: Left drives `ctl_left`=1 and `ctl_right`=0. Right drives the opposite. Left wins when both bits are set. The two lines are never high together.
- R5: A left or right drive also updates the data group. Elevation variant: set bits 0, 2 and 4, clear bit 7. Azimuth-only variant: set bits 0, 2, 4, 5 and 6, clear bits 1 and 3. Bits that no step names keep their value.
- R6: The elevation variant applies an elevation pattern before the azimuth pattern. Up: set bits 1, 4 and 5, clear bits 3 and 7. Down: set bits 1, 3, 4 and 5, clear bit 7. Neither: clear bits 1 and 5. Up wins over down. The azimuth-only variant leaves the data group unchanged for up and down.
- R7: A request with neither left nor right clears data bits 0, 2 and 6 and drops both lines.
- R8: `stop` takes effect on the next clock edge. It clears data bits 0, 1, 2, 5 and 6, drops both lines and engages the brake. It also forgets the remembered move, aborts any request in flight and suppresses its acknowledge.
- R9: A request is taken when `req_valid` is high in idle. `req_ack` is a one-cycle pulse. It rises on the 4th edge, counting the accepting edge as the 1st, plus `CLK_KHZ*SETTLE_MS` cycles if a settle pause ran and `CLK_KHZ*BRAKE_MS` cycles if a brake pause ran. During a pause no request is taken and the outputs do not change.
- R10: After reset the data group is 0, both lines are low, the acknowledge is low, the brake is engaged and no move is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Emergency stop, highest priority |
| req_valid | input | 1 | Request present; hold until `req_ack` |
| req_dir | input | 4 | Bit 0 left, bit 1 right, bit 2 up, bit 3 down |
| req_ack | output | 1 | One-cycle pulse: new relay state is in effect |
| data_out | output | 8 | Relay data group |
| ctl_left | output | 1 | Azimuth left direction line |
| ctl_right | output | 1 | Azimuth right direction line |

## Verification
A wrong remembered move or brake flag does not show up at once. It appears on the next request as an acknowledge that comes one full pause early or late. So every request is timed against a model, and random direction sequences exercise reversals, repeats and releases. A wrong data mask shows on the data group in the same cycle as the acknowledge. Because the group is read-modify-write, a missed clear can surface several requests later. Both wiring variants run side by side, and stops are injected in the middle of pauses.

// File: rtl/rot_seq_pkg.sv
package rot_seq_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] dbits_t;

  typedef struct packed {
    dbits_t set;
    dbits_t clr;
  } dmask_t;

  // direction request bit positions
  localparam int DIR_L = 0;
  localparam int DIR_R = 1;
  localparam int DIR_U = 2;
  localparam int DIR_D = 3;

  localparam dbits_t AUX_BITS  = 8'h45;  // bits 0,2,6
  localparam dbits_t ELV_BITS  = 8'h22;  // bits 1,5
  localparam dbits_t STOP_BITS = AUX_BITS | ELV_BITS;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_WAIT_S, S_REL, S_WAIT_B, S_DRIVE
  } seq_state_t;

  function automatic dbits_t apply_mask(dbits_t d, dmask_t m);
    return (d & ~m.clr) | m.set;
  endfunction
endpackage

// File: rtl/rot_delay.sv
module rot_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rot_patterns.sv
module rot_patterns
  import rot_seq_pkg::*;
#(
  parameter bit HAS_EL = 1'b1
) (
  input  logic [3:0] dir,
  output dmask_t     rel_m,
  output dmask_t     el_m,
  output dmask_t     az_m,
  output logic [1:0] az_lines   // [0] left, [1] right
);
  logic az_any;
  assign az_any   = dir[DIR_L] | dir[DIR_R];
  assign az_lines = dir[DIR_L] ? 2'b01 : (dir[DIR_R] ? 2'b10 : 2'b00);

  generate
    if (HAS_EL) begin : g_azel
      assign rel_m = '{set: 8'h55, clr: 8'h80};
      always_comb begin
        if (dir[DIR_U])      el_m = '{set: 8'h32, clr: 8'h88};
        else if (dir[DIR_D]) el_m = '{set: 8'h3A, clr: 8'h80};
        else                 el_m = '{set: 8'h00, clr: ELV_BITS};
        az_m = az_any ? '{set: 8'h15, clr: 8'h80} : '{set: 8'h00, clr: AUX_BITS};
      end
    end else begin : g_az
      assign rel_m = '{set: 8'hF5, clr: 8'h0A};
      assign el_m  = '{set: 8'h00, clr: 8'h00};
      assign az_m  = az_any ? '{set: 8'h75, clr: 8'h0A} : '{set: 8'h00, clr: AUX_BITS};
    end
  endgenerate
endmodule

// File: rtl/rotor_relay_seq.sv
module rotor_relay_seq
  import rot_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int SETTLE_MS = 500,
  parameter int BRAKE_MS  = 100,
  parameter bit HAS_EL    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop,
  input  logic       req_valid,
  input  logic [3:0] req_dir,
  output logic       req_ack,
  output logic [7:0] data_out,
  output logic       ctl_left,
  output logic       ctl_right
);
  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_MS;
  localparam int BRAKE_CYC  = CLK_KHZ * BRAKE_MS;
  localparam int MAX_CYC    = (SETTLE_CYC > BRAKE_CYC) ? SETTLE_CYC : BRAKE_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  seq_state_t state;
  logic [3:0] dir_q, move_q;
  logic       brake_rel;
  dbits_t     data_q;
  logic [1:0] ctl_q;
  logic       ack_q;

  dmask_t     rel_m, el_m, az_m;
  logic [1:0] az_lines;
  logic       az_rev, el_rev, az_req, need_settle;
  logic       load_settle, load_brake, expired;
  logic [CW-1:0] load_val;
  dbits_t     prep_clr;

  rot_patterns #(.HAS_EL(HAS_EL)) u_pat (
    .dir(dir_q), .rel_m(rel_m), .el_m(el_m), .az_m(az_m), .az_lines(az_lines)
  );

  always_comb begin
    az_rev = (move_q[DIR_L] && dir_q[DIR_R]) || (move_q[DIR_R] && dir_q[DIR_L]);
    el_rev = HAS_EL && ((move_q[DIR_U] && dir_q[DIR_D]) || (move_q[DIR_D] && dir_q[DIR_U]));
    az_req = dir_q[DIR_L] | dir_q[DIR_R];
    need_settle = az_rev || el_rev;
    prep_clr = (az_rev ? AUX_BITS : '0) | (el_rev ? ELV_BITS : '0);
    load_settle = (state == S_PREP) && need_settle;
    load_brake  = (state == S_REL) && !brake_rel && az_req;
    load_val    = load_settle ? CW'(SETTLE_CYC - 1) : CW'(BRAKE_CYC - 1);
  end

  rot_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst(rst), .clr(stop),
    .load(load_settle || load_brake), .load_val(load_val), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; dir_q <= '0; move_q <= '0; brake_rel <= 1'b0;
      data_q <= '0; ctl_q <= '0; ack_q <= 1'b0;
    end else if (stop) begin
      state <= S_IDLE; move_q <= '0; brake_rel <= 1'b0;
      data_q <= data_q & ~STOP_BITS; ctl_q <= '0; ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          dir_q <= req_dir;
          state <= S_PREP;
        end
        S_PREP: begin
          data_q <= data_q & ~prep_clr;
          if (az_rev) begin
            ctl_q     <= '0;
            brake_rel <= 1'b0;
          end
          state <= need_settle ? S_WAIT_S : S_REL;
        end
        S_WAIT_S: if (expired) state <= S_REL;
        S_REL: begin
          move_q <= dir_q;
          if (!brake_rel && az_req) begin
            ctl_q     <= '0;
            data_q    <= apply_mask(data_q, rel_m);
            brake_rel <= 1'b1;
            state     <= S_WAIT_B;
          end else begin
            state <= S_DRIVE;
          end
        end
        S_WAIT_B: if (expired) state <= S_DRIVE;
        S_DRIVE: begin
          data_q <= apply_mask(apply_mask(data_q, el_m), az_m);
          ctl_q  <= az_lines;
          ack_q  <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ack   = ack_q;
  assign data_out  = data_q;
  assign ctl_left  = ctl_q[0];
  assign ctl_right = ctl_q[1];

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ctl_left && ctl_right)); // R4
  AST_RIGHT_FROM_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_right) |-> !$past(ctl_left)); // R1
  AST_LEFT_FROM_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_left) |-> !$past(ctl_right)); // R1
  AST_STOP_SAFE: assert property (@(posedge clk) disable iff (rst)
    stop |=> ((data_out & STOP_BITS) == '0) && !ctl_left && !ctl_right && !req_ack); // R8
  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (rst)
    ((state == S_WAIT_S || state == S_WAIT_B) && !stop) |=>
      $stable(data_out) && $stable(ctl_left) && $stable(ctl_right) && !req_ack); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R9
endmodule

// File: tb/test_rotor_relay_seq.sv
module test_rotor_relay_seq;
  localparam int KHZ = 2;
  localparam int SMS = 500;
  localparam int BMS = 100;
  localparam int S_CYC = KHZ * SMS;
  localparam int B_CYC = KHZ * BMS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, stop = 1'b0;
  logic [3:0] req_dir = '0;
  logic v_el = 1'b0, v_az = 1'b0;
  logic ack_el, ack_az, l_el, r_el, l_az, r_az;
  logic [7:0] d_el, d_az;

  rotor_relay_seq #(.CLK_KHZ(KHZ), .SETTLE_MS(SMS), .BRAKE_MS(BMS), .HAS_EL(1'b1)) i_rotor_relay_seq (
    .clk(clk), .rst(rst), .stop(stop), .req_valid(v_el), .req_dir(req_dir),
    .req_ack(ack_el), .data_out(d_el), .ctl_left(l_el), .ctl_right(r_el));

  rotor_relay_seq #(.CLK_KHZ(KHZ), .SETTLE_MS(SMS), .BRAKE_MS(BMS), .HAS_EL(1'b0)) i_rotor_relay_seq_az (
    .clk(clk), .rst(rst), .stop(stop), .req_valid(v_az), .req_dir(req_dir),
    .req_ack(ack_az), .data_out(d_az), .ctl_left(l_az), .ctl_right(r_az));

  int errors = 0, checks = 0;
  logic [7:0] md [2];
  logic [1:0] mc [2];
  logic       mb [2];
  logic [3:0] mv [2];

  function automatic logic [7:0] dat(int v); return v ? d_el : d_az; endfunction
  function automatic logic [1:0] ctl(int v); return v ? {r_el, l_el} : {r_az, l_az}; endfunction
  function automatic logic ack(int v); return v ? ack_el : ack_az; endfunction
  function automatic logic [7:0] msk(logic [7:0] d, logic [7:0] s, logic [7:0] c);
    return (d & ~c) | s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected effect of one request on variant v (1 = elevation variant)
  task automatic model(input int v, input logic [3:0] d, output int lat);
    bit settle = 0;
    if ((mv[v][0] && d[1]) || (mv[v][1] && d[0])) begin
      md[v] &= ~8'h45; mc[v] = 2'b00; mb[v] = 0; settle = 1;
    end
    if (v == 1 && ((mv[v][2] && d[3]) || (mv[v][3] && d[2]))) begin
      md[v] &= ~8'h22; settle = 1;
    end
    mv[v] = d;
    lat = 3 + (settle ? S_CYC : 0);
    if (!mb[v] && (d[0] || d[1])) begin
      mc[v] = 2'b00;
      md[v] = v ? msk(md[v], 8'h55, 8'h80) : msk(md[v], 8'hF5, 8'h0A);
      mb[v] = 1; lat += B_CYC;
    end
    if (v == 1) begin
      if (d[2])      md[v] = msk(md[v], 8'h32, 8'h88);
      else if (d[3]) md[v] = msk(md[v], 8'h3A, 8'h80);
      else           md[v] = msk(md[v], 8'h00, 8'h22);
    end
    if (d[0] || d[1]) begin
      md[v] = v ? msk(md[v], 8'h15, 8'h80) : msk(md[v], 8'h75, 8'h0A);
      mc[v] = d[0] ? 2'b01 : 2'b10;
    end else begin
      md[v] &= ~8'h45; mc[v] = 2'b00;
    end
  endtask

  task automatic do_req(input logic [3:0] d, input string tag);
    int lat [2];
    bit done [2];
    int n = 0;
    model(0, d, lat[0]);
    model(1, d, lat[1]);
    done[0] = 0; done[1] = 0;
    @(negedge clk); req_dir = d; v_az = 1; v_el = 1;
    while (!(done[0] && done[1]) && n < 3000) begin
      @(negedge clk); n++;
      for (int v = 0; v < 2; v++) begin
        if (!done[v] && ack(v)) begin
          done[v] = 1;
          if (v) v_el = 0; else v_az = 0;
          check(n == lat[v] + 1, {tag, " R9 ack latency"}, n, lat[v] + 1);
          check(dat(v) == md[v], {tag, " R5/R6 data group"}, dat(v), md[v]);
          check(ctl(v) == mc[v], {tag, " R4 direction lines"}, ctl(v), mc[v]);
        end
      end
    end
    for (int v = 0; v < 2; v++)
      if (!done[v]) check(0, {tag, " R9 no acknowledge"}, 0, 1);
    v_az = 0; v_el = 0;
    @(negedge clk);
    check(!ack_el && !ack_az, "R9 ack is one cycle", {ack_el, ack_az}, 0);
  endtask

  task automatic pulse_stop(input string tag);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    for (int v = 0; v < 2; v++) begin
      md[v] &= ~8'h67; mc[v] = 2'b00; mb[v] = 0; mv[v] = 4'b0000;
      check(dat(v) == md[v], {tag, " R8 stop data"}, dat(v), md[v]);
      check(ctl(v) == 2'b00, {tag, " R8 stop lines"}, ctl(v), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int v = 0; v < 2; v++) begin md[v] = 0; mc[v] = 0; mb[v] = 0; mv[v] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check(dat(v) == 8'h00, "R10 reset data", dat(v), 0);
      check(ctl(v) == 2'b00 && !ack(v), "R10 reset lines/ack", {ctl(v), ack(v)}, 0);
    end

    do_req(4'b0001, "R10 R3 first left pays brake");
    do_req(4'b0001, "R3 repeat left no pause");
    do_req(4'b0010, "R1 reversal to right");
    do_req(4'b0100, "R7 up only clears azimuth");
    do_req(4'b1000, "R2 up-to-down reversal");
    do_req(4'b0001, "R3 brake stays released");
    do_req(4'b0011, "R4 left wins");
    do_req(4'b0110, "R1 R6 right plus up");
    do_req(4'b1100, "R6 up wins over down");
    do_req(4'b0000, "R7 none");
    pulse_stop("R8 idle stop");
    do_req(4'b0100, "R3 elevation never waits for brake");

    // stop in the middle of a brake pause
    pulse_stop("R8 pre");
    @(negedge clk); req_dir = 4'b0001; v_az = 1; v_el = 1;
    repeat (6) @(negedge clk);
    v_az = 0; v_el = 0;
    md[1] = msk(md[1], 8'h55, 8'h80);
    md[0] = msk(md[0], 8'hF5, 8'h0A);
    pulse_stop("R8 mid-pause");
    begin
      bit seen = 0;
      repeat (B_CYC + 20) begin
        @(negedge clk);
        if (ack_el || ack_az) seen = 1;
      end
      check(!seen, "R8 aborted request not acknowledged", seen, 0);
    end
    do_req(4'b0010, "R8 move forgotten after stop");

    begin
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 70; i++) begin
        if (($urandom % 10) == 0) pulse_stop("R8 random stop");
        else do_req(4'($urandom % 16), "random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule